// File: doc/BRIEF.md
# Packed Decimal to Binary Converter

This block turns a signed packed decimal number, delivered one byte at a time, into a 32-bit two's complement integer. Each byte holds two decimal digits, one per nibble. The number's final byte holds its least significant digit in the upper nibble and a sign code in the lower nibble. Numbers always have an odd digit count, so that the digits and the sign fill whole bytes. A value with an even number of digits is given a leading zero digit.

Bytes arrive most significant first, on a valid/ready input with a marker on the final byte. One cycle after the final byte is accepted, a one-cycle done strobe presents the converted value together with an error flag. No decimal point is carried. Any scaling of the integer is left to the consumer. A new number may begin in the cycle right after the final byte of the previous one.

Top module: `pdec2bin`

## Requirements
- R1: While `rst` is high, `out_done`, `out_err`, `out_value` and `in_ready` are all 0. In the first cycle after reset is released, `in_ready` is 1.
- R2: A byte is consumed when `in_valid` and `in_ready` are both high. Bits [7:4] of the byte hold the more significant digit and bits [3:0] the less significant one. A final byte whose bits [3:0] are 0xC gives a non-negative result. For example, 98 6C gives 986 and 7C gives 7.
- R3: A sign nibble of 0xD gives the two's complement negation of the magnitude: 02 04 8D gives -2048. A negative zero (0D) gives 0 with no error.
- R4: Digits across bytes combine most significant byte first: 01 02 4C gives 1024 and 12 34 5C gives 12345.
- R5: `out_done` is high for exactly the one cycle that follows the edge at which a byte with `in_last` high is consumed, and is low in every other cycle. `out_value` and `out_err` change only in a cycle where `out_done` is high.
- R6: The first byte after a completed number starts a fresh accumulation. Nothing from the previous number, including its error, carries over.
- R7: Any digit nibble above 9 sets `out_err` and forces `out_value` to 0.
- R8: A sign nibble other than 0xC or 0xD sets `out_err` and forces `out_value` to 0.
- R9: Up to 5 bytes (9 digits) convert normally; 999999999 converts to 0x3B9AC9FF. A number of 6 or more bytes sets `out_err` and forces `out_value` to 0.
- R10: A cycle with `in_valid` low consumes nothing, whatever is on `in_byte` and `in_last`. It produces no strobe and leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is offered on `in_byte` |
| in_ready | output | 1 | The block can take a byte |
| in_byte | input | 8 | Two packed nibbles, more significant in bits [7:4] |
| in_last | input | 1 | This byte ends the number; its low nibble is the sign |
| out_done | output | 1 | One-cycle strobe: result fields are fresh |
| out_value | output | 32 | Signed two's complement result, 0 on error |
| out_err | output | 1 | The number just finished was malformed |

## Verification
A stale accumulator or a missed clear shows up in the value presented with the very next strobe. Such a fault is visible at the ports one cycle after the faulty number's final byte. An error flag that sticks shows up as a wrong `out_err` on the following well-formed number. A byte counter that is off by one is exposed by the 5-byte and 6-byte streams. Stall cycles between bytes, which carry junk data and a raised last marker, catch any leak from invalid cycles through a spurious strobe or a corrupted value.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    localparam logic [3:0] SIGN_PLUS  = 4'hC;
    localparam logic [3:0] SIGN_MINUS = 4'hD;

    typedef struct packed {
        logic [3:0] hi;
        logic [3:0] lo;
    } pbyte_t;

    typedef enum logic [1:0] {
        SGN_POS = 2'd0,
        SGN_NEG = 2'd1,
        SGN_BAD = 2'd2
    } sign_t;

    function automatic logic is_digit(input logic [3:0] n);
        return n <= 4'd9;
    endfunction

    function automatic sign_t decode_sign(input logic [3:0] n);
        if (n == SIGN_PLUS)  return SGN_POS;
        if (n == SIGN_MINUS) return SGN_NEG;
        return SGN_BAD;
    endfunction

endpackage

// File: rtl/pdec_nib_chk.sv
module pdec_nib_chk
    import pdec_pkg::*;
(
    input  pbyte_t b,
    output logic   hi_ok,
    output logic   lo_ok,
    output sign_t  sgn
);
    always_comb begin
        hi_ok = is_digit(b.hi);
        lo_ok = is_digit(b.lo);
        sgn   = decode_sign(b.lo);
    end
endmodule

// File: rtl/pdec_accum.sv
module pdec_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         clear,
    input  logic         two,
    input  logic [3:0]   hi,
    input  logic [3:0]   lo,
    output logic [W-1:0] acc_nxt
);
    logic [W-1:0] acc_q;
    logic [W-1:0] base;
    logic [W-1:0] step1;

    always_comb begin
        base  = clear ? '0 : acc_q;
        step1 = base * W'(10) + W'(hi);
        acc_nxt = two ? (step1 * W'(10) + W'(lo)) : step1;
    end

    always_ff @(posedge clk) begin
        if (rst)     acc_q <= '0;
        else if (en) acc_q <= acc_nxt;
    end

    // R6: a fresh number holds at most two digits after its first byte
    a_r6_fresh_start: assert property (@(posedge clk) disable iff (rst)
        (en && clear) |=> (acc_q < W'(100)));
endmodule

// File: rtl/pdec_len_cnt.sv
module pdec_len_cnt #(
    parameter int MAX_BYTES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic beat,
    input  logic first,
    output logic over
);
    localparam int CW = $clog2(MAX_BYTES + 2);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_BYTES);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        if (first)              cnt_nxt = CW'(1);
        else if (cnt_q > LIMIT) cnt_nxt = cnt_q;
        else                    cnt_nxt = cnt_q + CW'(1);
        over = cnt_nxt > LIMIT;
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (beat) cnt_q <= cnt_nxt;
    end

    // R9: the first byte of a number never counts as too long
    a_r9_first_ok: assert property (@(posedge clk) disable iff (rst)
        (beat && first) |-> !over);
endmodule

// File: rtl/pdec2bin.sv
module pdec2bin
    import pdec_pkg::*;
#(
    parameter int OUT_W     = 32,
    parameter int MAX_BYTES = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    input  logic             in_last,
    output logic             out_done,
    output logic [OUT_W-1:0] out_value,
    output logic             out_err
);
    pbyte_t           pb;
    logic             beat;
    logic             first_q;
    logic             err_q;
    logic             hi_ok, lo_ok, over;
    sign_t            sgn;
    logic [OUT_W-1:0] acc_nxt;
    logic             bad_now;
    logic             err_all;
    logic             rdy_q;

    assign pb       = pbyte_t'(in_byte);
    assign in_ready = rdy_q;
    assign beat     = in_valid && rdy_q;

    pdec_nib_chk u_chk (
        .b     (pb),
        .hi_ok (hi_ok),
        .lo_ok (lo_ok),
        .sgn   (sgn)
    );

    pdec_accum #(.W(OUT_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (beat),
        .clear   (first_q),
        .two     (!in_last),
        .hi      (pb.hi),
        .lo      (pb.lo),
        .acc_nxt (acc_nxt)
    );

    pdec_len_cnt #(.MAX_BYTES(MAX_BYTES)) u_len (
        .clk   (clk),
        .rst   (rst),
        .beat  (beat),
        .first (first_q),
        .over  (over)
    );

    always_comb begin
        bad_now = !hi_ok || over ||
                  (in_last ? (sgn == SGN_BAD) : !lo_ok);
        err_all = (!first_q && err_q) || bad_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q     <= 1'b0;
            first_q   <= 1'b1;
            err_q     <= 1'b0;
            out_done  <= 1'b0;
            out_value <= '0;
            out_err   <= 1'b0;
        end else begin
            rdy_q    <= 1'b1;
            out_done <= beat && in_last;
            if (beat) begin
                first_q <= in_last;
                err_q   <= err_all;
                if (in_last) begin
                    out_err <= err_all;
                    if (err_all)             out_value <= '0;
                    else if (sgn == SGN_NEG) out_value <= -acc_nxt;
                    else                     out_value <= acc_nxt;
                end
            end
        end
    end

    // R5: strobe exactly after a consumed final byte
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (beat && in_last) |=> out_done);
    a_r5_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !(beat && in_last) |=> !out_done);
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_value) && $stable(out_err)));
    // R7 / R8 / R9: an error suppresses the value
    a_r7_err_zero: assert property (@(posedge clk) disable iff (rst)
        (out_done && out_err) |-> (out_value == '0));
    a_r8_bad_sign: assert property (@(posedge clk) disable iff (rst)
        (beat && in_last && pb.lo != SIGN_PLUS && pb.lo != SIGN_MINUS) |=> out_err);
    a_r9_long: assert property (@(posedge clk) disable iff (rst)
        (beat && in_last && over) |=> out_err);
    // R3: sign of the result follows the sign code
    a_r3_sign: assert property (@(posedge clk) disable iff (rst)
        (beat && in_last && !err_all && pb.lo == SIGN_PLUS) |=> !out_value[OUT_W-1]);
endmodule

// File: tb/pdec2bin_bench.sv
`timescale 1ns/1ps
module pdec2bin_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        in_last = 1'b0;
    logic        out_done;
    logic [31:0] out_value;
    logic        out_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pdec2bin u_pdec2bin (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_last(in_last), .out_done(out_done),
        .out_value(out_value), .out_err(out_err)
    );

    // {bytes left aligned, byte count, expected value, expected error, tag}
    localparam int NV = 14;
    localparam logic [88:0] TBL [NV] = '{
        {48'h01024C000000, 4'd3, 32'h00000400, 1'b0, 4'd4},
        {48'h02048D000000, 4'd3, 32'hFFFFF800, 1'b0, 4'd3},
        {48'h0314159D0000, 4'd4, 32'hFFFB34D1, 1'b0, 4'd3},
        {48'h986C00000000, 4'd2, 32'h000003DA, 1'b0, 4'd2},
        {48'h7C0000000000, 4'd1, 32'h00000007, 1'b0, 4'd2},
        {48'h0D0000000000, 4'd1, 32'h00000000, 1'b0, 4'd3},
        {48'h999999999C00, 4'd5, 32'h3B9AC9FF, 1'b0, 4'd9},
        {48'h999999999D00, 4'd5, 32'hC4653601, 1'b0, 4'd9},
        {48'h1A5C00000000, 4'd2, 32'h00000000, 1'b1, 4'd7},
        {48'h123F00000000, 4'd2, 32'h00000000, 1'b1, 4'd8},
        {48'h00000000001C, 4'd6, 32'h00000000, 1'b1, 4'd9},
        {48'h12345C000000, 4'd3, 32'h00003039, 1'b0, 4'd4},
        {48'h0B3C00000000, 4'd2, 32'h00000000, 1'b1, 4'd7},
        {48'h12EC00000000, 4'd2, 32'h00000000, 1'b1, 4'd7}
    };

    function automatic string tag_of(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge; returns at the falling edge where the result shows
    task automatic send(input logic [47:0] bytes, input int n, input bit stall);
        for (int i = 0; i < n; i++) begin
            in_byte  = bytes[47 - 8*i -: 8];
            in_valid = 1'b1;
            in_last  = (i == n - 1);
            @(posedge clk); @(negedge clk);
            if (stall && i != n - 1) begin
                in_valid = 1'b0;
                in_byte  = 8'hFF;
                in_last  = 1'b1;
                @(posedge clk); @(negedge clk);
                check("R10 stall strobe", {31'd0, out_done}, 32'd0);
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 done", {31'd0, out_done}, 32'd0);
        check("R1 err", {31'd0, out_err}, 32'd0);
        check("R1 value", out_value, 32'd0);
        check("R1 ready low", {31'd0, in_ready}, 32'd0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 ready high", {31'd0, in_ready}, 32'd1);

        for (int k = 0; k < NV; k++) begin
            logic [88:0] e;
            string t;
            e = TBL[k];
            t = tag_of(int'(e[3:0]));
            send(e[88:41], int'(e[40:37]), k[0]);
            check({t, " done"}, {31'd0, out_done}, 32'd1);
            check({t, " value"}, out_value, e[36:5]);
            check({t, " err"}, {31'd0, out_err}, {31'd0, e[4]});
            @(posedge clk); @(negedge clk);
            check("R5 single pulse", {31'd0, out_done}, 32'd0);
            check("R5 value held", out_value, e[36:5]);
        end

        // R6: error number followed at once by a good one
        send(48'h1A5C00000000, 2, 1'b0);
        check("R6 prior err", {31'd0, out_err}, 32'd1);
        send(48'h3C0000000000, 1, 1'b0);
        check("R6 fresh value", out_value, 32'd3);
        check("R6 fresh err", {31'd0, out_err}, 32'd0);
        // R6: good number then good number back to back
        send(48'h5C0000000000, 1, 1'b0);
        send(48'h4D0000000000, 1, 1'b0);
        check("R6 no carry", out_value, 32'hFFFFFFFC);

        // R10: idle cycles with a raised last marker change nothing
        in_byte = 8'h9D; in_last = 1'b1; in_valid = 1'b0;
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            check("R10 idle strobe", {31'd0, out_done}, 32'd0);
        end
        check("R10 idle value", out_value, 32'hFFFFFFFC);
        in_last = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule